// File: doc/BRIEF.md
# Prescaled Interval Timer with Sticky Expiry Flag

This block is an 8-bit down-counter for measuring intervals. Software starts it with a single bus write. The address bits of that write carry the control settings: two of them pick how many clock-enable ticks pass between decrements (1, 8, 64 or 1024), and a third decides whether expiry raises the interrupt. No separate control register is needed, and one store both starts a delay and sets its resolution.

When the count steps down to zero, an expiry flag is set. The flag stays set until software reads the flag register. After expiry the counter switches to decrementing on every tick and wraps through 0xFF. Software can read this fast count to see how long ago the timer ran out. The interrupt output is active low. It is driven while the flag is set and interrupts were enabled on the last load.

The block sits behind a simple register bus. The bus has a select strobe, a write/read direction bit, five address bits and 8-bit data. Reads are combinational from the stored state. Any clearing of state takes effect at the next clock.

Top module: `interval_timer`

## Requirements
- R1: Reset (synchronous, rst_n low at a clock edge) leaves the following state: count 0xFF, expiry flag clear, interrupt disabled, irq_n high, and a prescale of 1024 ticks per decrement.
- R2: A load happens when bus_sel=1, bus_wr=1, bus_addr[4]=1 and bus_addr[2]=1 at a clock edge. The count then equals bus_wdata after that edge. Writes with bus_addr[4]=0 or bus_addr[2]=0 leave the count unchanged.
- R3: The divider is set from bus_addr[1:0] on the load: 00 gives 1 tick, 01 gives 8, 10 gives 64 and 11 gives 1024 ticks per decrement. A load restarts the tick phase. The count does not change in cycles where tick_en is low.
- R4: When a decrement takes the count from 1 to 0, the expiry flag is set. The flag reads as bit 7 of the flag register.
- R5: A flag read is bus_sel=1, bus_wr=0, bus_addr[4]=0, bus_addr[2]=1, bus_addr[0]=1. It returns {flag, 7'b0} and clears the flag at that clock edge. If the count reaches zero in the same cycle as the read, the flag stays set. A load clears the flag. At all other times the flag holds.
- R6: Once expired, the count decrements on every tick and wraps from 0x00 to 0xFF. The next load returns the count to prescaled decrementing.
- R7: bus_addr[3]=1 on a load enables the interrupt and bus_addr[3]=0 disables it. irq_n is low exactly when the flag is set and the interrupt is enabled.
- R8: A count read is bus_sel=1, bus_wr=0, bus_addr[4]=1, bus_addr[2]=1. It returns the current count and changes nothing. Reads at any other address outside the flag register return 0x00.
- R9: A load of 0x00 does not set the flag. The count wraps to 0xFF after one prescale period and keeps its prescale until it reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Clock enable that paces the prescaler |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Access address; bits carry load controls |
| bus_wdata | input | 8 | Write data (load value) |
| bus_rdata | output | 8 | Read data, combinational |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check the cycle-level rules on every cycle. A load takes its data, and the count holds when no tick arrives. A 1-to-0 step raises the flag, and the flag only drops on a read or a load. Expired decrementing happens on every tick, and the interrupt is only driven while the flag is set and enabled. The exact prescale period for each of the four divider codes can only be shown by the bench scenarios. The same holds for the zero-load wrap, for a clearing read that coincides with the zero crossing, and for the values seen at the read port.

// File: rtl/itmr_pkg.sv
// Package: shared widths, address bit positions and divider codes for the
// interval timer. Assumes a 5-bit register address and an 8-bit data path.
package itmr_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 5;
    localparam int SH_MAX  = 10;            // log2 of the largest divider
    localparam int PHASE_W = SH_MAX;

    // Address bit positions the decode depends on
    localparam int A_BANK  = 4;
    localparam int A_TIMER = 2;
    localparam int A_IEN   = 3;
    localparam int A_FLAG  = 0;

    typedef enum logic [1:0] {
        PS_DIV1    = 2'b00,
        PS_DIV8    = 2'b01,
        PS_DIV64   = 2'b10,
        PS_DIV1024 = 2'b11
    } ps_sel_t;

    // Last phase value before a decrement, per divider code
    function automatic logic [PHASE_W-1:0] last_phase(ps_sel_t s);
        logic [PHASE_W:0] one;
        one = {{PHASE_W{1'b0}}, 1'b1};
        case (s)
            PS_DIV1:    last_phase = '0;
            PS_DIV8:    last_phase = PHASE_W'((one << 3) - 1);
            PS_DIV64:   last_phase = PHASE_W'((one << 6) - 1);
            default:    last_phase = PHASE_W'((one << SH_MAX) - 1);
        endcase
    endfunction
endpackage

// File: rtl/itmr_decode.sv
// Bus decode: turns one strobed access into load / count-read / flag-read
// pulses and extracts the load controls from the address.
// Assumes bus_sel marks exactly one access per cycle it is high.
module itmr_decode
    import itmr_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              load_stb,
    output logic              cnt_rd,
    output logic              flg_rd,
    output ps_sel_t           ld_ps,
    output logic              ld_ien
);
    logic timer_hit;

    // Combinational address decode
    always_comb begin
        timer_hit = bus_sel && bus_addr[A_TIMER];
        load_stb  = timer_hit && bus_wr && bus_addr[A_BANK];
        cnt_rd    = timer_hit && !bus_wr && bus_addr[A_BANK];
        flg_rd    = timer_hit && !bus_wr && !bus_addr[A_BANK] && bus_addr[A_FLAG];
        ld_ps     = ps_sel_t'(bus_addr[1:0]);
        ld_ien    = bus_addr[A_IEN];
    end
endmodule

// File: rtl/itmr_prescale.sv
// Prescaler: counts clock-enable ticks and emits a one-cycle step at the
// end of each divider period. Once expired, it steps on every tick.
// Assumes a load restarts the phase at zero.
module itmr_prescale
    import itmr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick_en,
    input  logic    load_stb,
    input  ps_sel_t ld_ps,
    input  logic    expired,
    output logic    step
);
    ps_sel_t            ps_q;
    logic [PHASE_W-1:0] phase_q;
    logic               at_end;

    // Decide whether this tick ends a period
    always_comb begin
        at_end = (phase_q == last_phase(ps_q));
        step   = tick_en && !load_stb && (expired || at_end);
    end

    // Hold the divider code and advance the tick phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q    <= PS_DIV1024;
            phase_q <= '0;
        end else if (load_stb) begin
            ps_q    <= ld_ps;
            phase_q <= '0;
        end else if (tick_en && !expired) begin
            phase_q <= at_end ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/itmr_count.sv
// Down-counter: loads on a write, decrements on each prescaler step, and
// marks expiry on the 1-to-0 step. After expiry it wraps freely.
// Assumes load has priority over a step in the same cycle.
module itmr_count
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_stb,
    input  logic [DATA_W-1:0] load_val,
    input  logic              step,
    output logic [DATA_W-1:0] cnt_q,
    output logic              expired_q,
    output logic              reach_zero
);
    // Detect the step that lands on zero
    always_comb begin
        reach_zero = step && !expired_q && (cnt_q == DATA_W'(1));
    end

    // Count register and expiry state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '1;
            expired_q <= 1'b0;
        end else if (load_stb) begin
            cnt_q     <= load_val;
            expired_q <= 1'b0;
        end else if (step) begin
            cnt_q <= cnt_q - 1'b1;
            if (reach_zero) expired_q <= 1'b1;
        end
    end
endmodule

// File: rtl/itmr_flag.sv
// Expiry flag and interrupt enable. The flag is set on zero, cleared by a
// flag read or a load; a set in the same cycle as a read wins.
module itmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic load_stb,
    input  logic ld_ien,
    input  logic reach_zero,
    input  logic flg_rd,
    output logic flag_q,
    output logic ien_q,
    output logic irq_n
);
    // Active-low interrupt request
    always_comb irq_n = !(flag_q && ien_q);

    // Sticky flag and enable bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            ien_q  <= 1'b0;
        end else begin
            if (load_stb) ien_q <= ld_ien;
            if (reach_zero)                flag_q <= 1'b1;
            else if (load_stb || flg_rd)   flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/interval_timer.sv
// Top: prescaled 8-bit interval timer on a simple register bus.
// Assumes tick_en is synchronous to clk. Read data is combinational.
module interval_timer
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n
);
    logic              load_stb, cnt_rd, flg_rd, ld_ien;
    ps_sel_t           ld_ps;
    logic              step, reach_zero;
    logic [DATA_W-1:0] cnt_q;
    logic              expired_q, flag_q, ien_q;

    itmr_decode u_dec (
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .load_stb(load_stb), .cnt_rd(cnt_rd), .flg_rd(flg_rd),
        .ld_ps(ld_ps), .ld_ien(ld_ien)
    );

    itmr_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_stb(load_stb),
        .ld_ps(ld_ps), .expired(expired_q), .step(step)
    );

    itmr_count u_cnt (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_val(bus_wdata),
        .step(step), .cnt_q(cnt_q), .expired_q(expired_q),
        .reach_zero(reach_zero)
    );

    itmr_flag u_flg (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .ld_ien(ld_ien),
        .reach_zero(reach_zero), .flg_rd(flg_rd), .flag_q(flag_q),
        .ien_q(ien_q), .irq_n(irq_n)
    );

    // Read data mux
    always_comb begin
        if (cnt_rd)      bus_rdata = cnt_q;
        else if (flg_rd) bus_rdata = {flag_q, {(DATA_W-1){1'b0}}};
        else             bus_rdata = '0;
    end
endmodule

// File: rtl/interval_timer_chk.sv
// Checker: cycle-level properties of the interval timer, bound to the top.
module interval_timer_chk
    import itmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_n,
    input logic [DATA_W-1:0] cnt_q,
    input logic              flag_q,
    input logic              ien_q,
    input logic              expired_q,
    input logic              load_stb
);
    logic flag_read;
    always_comb flag_read = bus_sel && !bus_wr && bus_addr[2] && !bus_addr[4] && bus_addr[0];

    AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> cnt_q == $past(bus_wdata)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load_stb) |=> $stable(cnt_q)); // R3
    AST_ZERO_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == 8'd1 && !expired_q && !load_stb) |=> (cnt_q == 8'd1 || flag_q)); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_read && !load_stb) |=> flag_q); // R5
    AST_LOAD_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !flag_q); // R5
    AST_FAST_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_q && tick_en && !load_stb) |=> cnt_q == 8'($past(cnt_q) - 8'd1)); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (flag_q && ien_q)); // R7
endmodule

bind interval_timer interval_timer_chk u_chk (.*);

// File: tb/interval_timer_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module interval_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_n;
    int         n_chk = 0;
    int         n_fail = 0;

    always #5 clk = ~clk;

    interval_timer u_interval_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Write one cycle; the state changes at the edge in between
    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Count read: no side effect, sampled away from the edge
    task automatic read_count(output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'b10100;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Flag read: returns value, clears at the following edge
    task automatic read_flag(output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'b00101;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        for (int i = 0; i < n; i++) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        read_count(v); check("R1 count", v, 8'hFF);
        check("R1 irq_n", irq_n, 1);
        read_flag(v); check("R1 flag", v, 8'h00);
        ticks(1023); read_count(v); check("R1 div1024 hold", v, 8'hFF);
        ticks(1); read_count(v); check("R1 div1024 step", v, 8'hFE);
    endtask

    task automatic t_decode;
        logic [7:0] v;
        bus_write(5'b10100, 8'h55);
        read_count(v); check("R2 load", v, 8'h55);
        bus_write(5'b00100, 8'h12);
        read_count(v); check("R2 no-bank write ignored", v, 8'h55);
        bus_write(5'b10000, 8'h34);
        read_count(v); check("R2 no-timer write ignored", v, 8'h55);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'b10000;
        #1 check("R8 other read zero", bus_rdata, 8'h00);
        @(negedge clk); bus_sel = 1'b0;
        read_count(v); check("R8 read no side effect", v, 8'h55);
    endtask

    task automatic t_prescale;
        logic [7:0] v;
        bus_write(5'b10100, 8'd4); ticks(1);
        read_count(v); check("R3 div1", v, 8'd3);
        bus_write(5'b10101, 8'd5); ticks(7);
        read_count(v); check("R3 div8 hold", v, 8'd5);
        ticks(1); read_count(v); check("R3 div8 step", v, 8'd4);
        ticks(8); read_count(v); check("R3 div8 second", v, 8'd3);
        bus_write(5'b10110, 8'd10); ticks(63);
        read_count(v); check("R3 div64 hold", v, 8'd10);
        ticks(1); read_count(v); check("R3 div64 step", v, 8'd9);
        ticks(5);
        bus_write(5'b10110, 8'd10); ticks(63);
        read_count(v); check("R3 phase restart", v, 8'd10);
        bus_write(5'b10111, 8'd3); ticks(1024);
        read_count(v); check("R3 div1024 step", v, 8'd2);
    endtask

    task automatic t_expiry_irq;
        logic [7:0] v;
        bus_write(5'b11100, 8'd2);
        check("R7 irq idle", irq_n, 1);
        ticks(2);
        read_count(v); check("R4 count zero", v, 8'd0);
        check("R7 irq low", irq_n, 0);
        read_flag(v); check("R4 flag bit7", v, 8'h80);
        check("R5 irq after clear", irq_n, 1);
        read_flag(v); check("R5 flag cleared", v, 8'h00);
        bus_write(5'b10100, 8'd1); ticks(1);
        read_flag(v); check("R7 flag when disabled", v, 8'h80);
        bus_write(5'b11100, 8'd1); ticks(1);
        ticks(3);
        check("R5 sticky", irq_n, 0);
        bus_write(5'b11100, 8'd9);
        check("R5 load clears", irq_n, 1);
        read_flag(v); check("R5 load clears flag", v, 8'h00);
    endtask

    task automatic t_disabled_irq;
        bus_write(5'b10100, 8'd1); ticks(1);
        check("R7 disabled irq_n", irq_n, 1);
    endtask

    task automatic t_fast;
        logic [7:0] v;
        bus_write(5'b10101, 8'd1); ticks(8);
        read_count(v); check("R6 zero", v, 8'd0);
        ticks(1); read_count(v); check("R6 wrap", v, 8'hFF);
        ticks(2); read_count(v); check("R6 fast", v, 8'hFD);
        bus_write(5'b10101, 8'd3); ticks(7);
        read_count(v); check("R6 prescale back", v, 8'd3);
    endtask

    task automatic t_race;
        logic [7:0] v;
        bus_write(5'b10100, 8'd1);
        @(negedge clk);
        tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'b00101;
        #1 check("R5 race read value", bus_rdata, 8'h00);
        @(negedge clk);
        tick_en = 1'b0; bus_sel = 1'b0;
        read_flag(v); check("R5 race flag kept", v, 8'h80);
    endtask

    task automatic t_zero_load;
        logic [7:0] v;
        bus_write(5'b10101, 8'd0); ticks(8);
        read_count(v); check("R9 wrap", v, 8'hFF);
        read_flag(v); check("R9 no flag", v, 8'h00);
        ticks(7); read_count(v); check("R9 still prescaled", v, 8'hFF);
        ticks(1); read_count(v); check("R9 step", v, 8'hFE);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_prescale();
        t_expiry_irq();
        t_disabled_irq();
        t_fast();
        t_race();
        t_zero_load();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule